// File: doc/BRIEF.md
# Interrupt Event Queue Writer

This block serves one target processor at one priority. It accepts notification requests. Each request carries the logical interrupt number that was configured for its source. For each accepted request it writes one 32-bit entry into a circular buffer in memory, through a single-cycle write port. Every entry holds a generation bit next to the logical number. The generation bit flips each time the buffer wraps. Software can therefore tell fresh entries from stale ones without sharing a read pointer with the hardware.

After an entry is posted, the block decides whether to signal the target. By default a queue-local pair of pending and queued bits (P and Q) coalesces notifications: the first entry notifies, and later entries only set Q. A write to the queue's EOI strobe then moves Q into P and signals the target again if P became 1. With the always-notify flag set, every entry signals the target and the P/Q pair is not touched.

A notification that the target cannot take is a failed notification. It raises a one-cycle escalation pulse when the escalate flag is set, and is dropped when the flag is clear.

A single configuration write sets the buffer base, the log2 byte size, and the enable, always-notify and escalate flags.

Top module: `evq_writer`

## Requirements
- R1: After reset the queue is disabled, the sticky drop flag is 0, and `mem_we`, `notify` and `escalate` are all 0.
- R2: An accepted request writes one entry at `base + 4*index`. The entry has the generation bit in bit 31 and the logical number in bits 30:0. All outputs of a request appear on the clock edge after the request is sampled and last exactly one cycle.
- R3: The buffer holds 2^(log2size-2) entries. After the last slot, the index returns to 0 and the generation bit inverts.
- R4: A request is dropped when the queue is disabled, or when the configured log2 size is 0, 1 or above MAX_LOG2. A dropped request causes no memory write and sets the sticky drop flag, which then stays set until reset.
- R5: A configuration write that turns a disabled queue on sets the index to 0 and the generation bit to 1. A configuration write to a queue that is already enabled keeps the current index and generation.
- R6: With always-notify set, every accepted request attempts a notification, whatever the P/Q state.
- R7: With always-notify clear, a request that finds P=0 sets P and attempts a notification. A request that finds P=1 sets Q and does not notify.
- R8: An EOI strobe copies Q into P and clears Q. It attempts a notification when the copied Q was 1.
- R9: An attempt made while `tgt_ready` is 1 pulses `notify`. An attempt made while `tgt_ready` is 0 pulses `escalate` if the escalate flag is set, and produces nothing otherwise. `notify` and `escalate` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_base | input | ADDR_W | Buffer base address, aligned to the buffer size |
| cfg_log2sz | input | 5 | Log2 of the buffer size in bytes; 0 disables |
| cfg_enable | input | 1 | Queue enable flag |
| cfg_always | input | 1 | Always-notify flag |
| cfg_escalate | input | 1 | Escalate-on-failure flag |
| req_valid | input | 1 | Notification request strobe |
| req_lirq | input | LIRQ_W | Logical interrupt number of the request |
| eoi_we | input | 1 | Queue EOI strobe |
| tgt_ready | input | 1 | Target can accept a notification this cycle |
| mem_we | output | 1 | Entry write strobe |
| mem_addr | output | ADDR_W | Entry byte address |
| mem_wdata | output | LIRQ_W+1 | Entry: generation bit and logical number |
| notify | output | 1 | Notification pulse to the target |
| escalate | output | 1 | Escalation pulse |
| err_drop | output | 1 | Sticky flag set by a dropped request |

## Verification
Every result is one register stage away from its stimulus. An entry write, a notification and an escalation all appear on the first rising edge after the request or EOI is sampled. A configuration write takes effect for requests sampled from the next edge on.

The bench drives inputs just after a falling edge and holds them for one full cycle. It checks the outputs at the following falling edge, which sits half a period after the edge where they change. It then checks one cycle later that every pulse has dropped again.

// File: rtl/evq_writer.sv
module evq_writer #(
  parameter int ADDR_W   = 32,
  parameter int LIRQ_W   = 31,
  parameter int MAX_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [4:0]        cfg_log2sz,
  input  logic              cfg_enable,
  input  logic              cfg_always,
  input  logic              cfg_escalate,
  input  logic              req_valid,
  input  logic [LIRQ_W-1:0] req_lirq,
  input  logic              eoi_we,
  input  logic              tgt_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LIRQ_W:0]   mem_wdata,
  output logic              notify,
  output logic              escalate,
  output logic              err_drop
);
  localparam int PTR_W = MAX_LOG2 - 2;
  localparam logic [4:0] LG_MAX = 5'(MAX_LOG2);

  logic [ADDR_W-1:0] base_q;
  logic [4:0]        lg_q;
  logic              en_q, alw_q, esc_q;
  logic [PTR_W-1:0]  ptr_q, last;
  logic              gen_q, p_q, q_q;
  logic              p1, q1, p2, q2, try_e, try_r;
  logic [31:0]       ents;

  wire active = en_q && lg_q >= 5'd2 && lg_q <= LG_MAX;
  wire post   = req_valid && active;
  wire wrap   = ptr_q == last;
  wire try_n  = try_e | try_r;

  always_comb begin
    ents = 32'd1;
    if (lg_q >= 5'd2) ents = 32'd1 << (lg_q - 5'd2);
    last = PTR_W'(ents - 32'd1);
  end

  always_comb begin
    p1 = p_q; q1 = q_q; try_e = 1'b0;
    if (eoi_we) begin
      try_e = q_q; p1 = q_q; q1 = 1'b0;
    end
    p2 = p1; q2 = q1; try_r = 1'b0;
    if (post) begin
      if (alw_q)    try_r = 1'b1;
      else if (!p1) begin p2 = 1'b1; try_r = 1'b1; end
      else          q2 = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; lg_q <= '0; en_q <= 1'b0; alw_q <= 1'b0; esc_q <= 1'b0;
      ptr_q <= '0; gen_q <= 1'b0; p_q <= 1'b0; q_q <= 1'b0;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      notify <= 1'b0; escalate <= 1'b0; err_drop <= 1'b0;
    end else begin
      if (cfg_we) begin
        base_q <= cfg_base; lg_q <= cfg_log2sz; en_q <= cfg_enable;
        alw_q <= cfg_always; esc_q <= cfg_escalate;
      end
      if (cfg_we && cfg_enable && !en_q) begin
        ptr_q <= '0; gen_q <= 1'b1;
      end else if (post) begin
        ptr_q <= wrap ? '0 : ptr_q + 1'b1;
        if (wrap) gen_q <= ~gen_q;
      end
      p_q       <= p2;
      q_q       <= q2;
      mem_we    <= post;
      mem_addr  <= base_q + ADDR_W'({ptr_q, 2'b00});
      mem_wdata <= {gen_q, req_lirq};
      notify    <= try_n && tgt_ready;
      escalate  <= try_n && !tgt_ready && esc_q;
      err_drop  <= err_drop | (req_valid && !active);
    end
  end
endmodule

// File: rtl/evq_writer_chk.sv
module evq_writer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              eoi_we,
  input logic              tgt_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              notify,
  input logic              escalate,
  input logic              err_drop,
  input logic              en,
  input logic              esc,
  input logic [ADDR_W-1:0] base,
  input logic [4:0]        lg
);
  assert_write_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(req_valid));
  assert_write_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(en));
  assert_addr_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (((mem_addr - $past(base)) >> $past(lg)) == '0));
  assert_drop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_drop) |-> err_drop);
  assert_notify_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(notify && escalate));
  assert_escalate_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    escalate |-> $past(!tgt_ready && esc));
  assert_notify_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> $past((req_valid || eoi_we) && tgt_ready));
endmodule

bind evq_writer evq_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .eoi_we(eoi_we),
  .tgt_ready(tgt_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .notify(notify), .escalate(escalate), .err_drop(err_drop),
  .en(en_q), .esc(esc_q), .base(base_q), .lg(lg_q)
);

// File: tb/evq_writer_tb.sv
module evq_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_enable = 1'b0, cfg_always = 1'b0, cfg_escalate = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_log2sz = '0;
  logic        req_valid = 1'b0, eoi_we = 1'b0, tgt_ready = 1'b1;
  logic [30:0] req_lirq = '0;
  logic        mem_we, notify, escalate, err_drop;
  logic [31:0] mem_addr, mem_wdata;
  int checks = 0, fails = 0;
  localparam logic [31:0] BASE = 32'h0000_1000;

  evq_writer u_dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cfgw(input logic [31:0] b, input logic [4:0] lg, input bit en, input bit alw, input bit esc);
    @(negedge clk);
    cfg_we = 1'b1; cfg_base = b; cfg_log2sz = lg; cfg_enable = en; cfg_always = alw; cfg_escalate = esc;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // one request; checks the next cycle and that pulses clear after
  task automatic post(input logic [30:0] lirq, input bit we, input logic [31:0] addr,
                      input bit gen, input bit ntf, input bit esc, input string tag);
    req_lirq = lirq; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    chk(mem_we == we, {tag, " mem_we"}, 32'(mem_we), 32'(we));
    if (we) begin
      chk(mem_addr == addr, {tag, " addr"}, mem_addr, addr);
      chk(mem_wdata == {gen, lirq}, {tag, " data"}, mem_wdata, {gen, lirq});
    end
    chk(notify == ntf, {tag, " notify"}, 32'(notify), 32'(ntf));
    chk(escalate == esc, {tag, " escalate"}, 32'(escalate), 32'(esc));
    @(negedge clk);
    chk(!mem_we && !notify && !escalate, {tag, " R2 pulse width"}, {29'd0, mem_we, notify, escalate}, 32'd0);
  endtask

  task automatic eoi(input bit ntf, input string tag);
    eoi_we = 1'b1;
    @(negedge clk); eoi_we = 1'b0;
    chk(notify == ntf, {tag, " notify"}, 32'(notify), 32'(ntf));
    chk(!mem_we && !escalate, {tag, " no write"}, {30'd0, mem_we, escalate}, 32'd0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!mem_we && !notify && !escalate && !err_drop, "R1 reset outputs",
        {28'd0, mem_we, notify, escalate, err_drop}, 32'd0);
    @(negedge clk);
    post(31'h11, 0, 0, 0, 0, 0, "R1 disabled after reset");
  endtask

  task automatic t_drops();
    do_reset();
    @(negedge clk);
    post(31'h5, 0, 0, 0, 0, 0, "R4 disabled drop");
    chk(err_drop, "R4 drop flag", 32'(err_drop), 32'd1);
    repeat (3) @(negedge clk);
    chk(err_drop, "R4 drop flag sticky", 32'(err_drop), 32'd1);
    do_reset();
    cfgw(BASE, 5'd0, 1, 0, 0);
    post(31'h6, 0, 0, 0, 0, 0, "R4 size zero drop");
    chk(err_drop, "R4 size zero flag", 32'(err_drop), 32'd1);
  endtask

  task automatic t_coalesce_wrap();
    do_reset();
    tgt_ready = 1'b1;
    cfgw(BASE, 5'd4, 1, 0, 0);
    post(31'h0A, 1, BASE + 0,  1, 1, 0, "R2 R7 first entry");
    post(31'h0B, 1, BASE + 4,  1, 0, 0, "R7 coalesced");
    post(31'h0C, 1, BASE + 8,  1, 0, 0, "R7 coalesced 2");
    post(31'h0D, 1, BASE + 12, 1, 0, 0, "R3 last slot");
    post(31'h0E, 1, BASE + 0,  0, 0, 0, "R3 wrap gen flip");
    eoi(1, "R8 eoi replay");
    eoi(0, "R8 eoi clears");
    post(31'h0F, 1, BASE + 4,  0, 1, 0, "R8 R7 after eoi");
    chk(!err_drop, "R4 no false drop", 32'(err_drop), 32'd0);
  endtask

  task automatic t_always_reenable();
    cfgw(BASE, 5'd4, 1, 1, 0);
    post(31'h21, 1, BASE + 8,  0, 1, 0, "R5 R6 keep ptr, always");
    post(31'h22, 1, BASE + 12, 0, 1, 0, "R6 always again");
    cfgw(BASE, 5'd4, 0, 1, 1);
    cfgw(BASE, 5'd4, 1, 1, 1);
    post(31'h23, 1, BASE + 0,  1, 1, 0, "R5 re-enable reset");
    tgt_ready = 1'b0;
    post(31'h24, 1, BASE + 4,  1, 0, 1, "R9 escalate");
    tgt_ready = 1'b1;
  endtask

  task automatic t_fail_no_esc();
    cfgw(BASE, 5'd4, 1, 0, 0);
    eoi(0, "R8 eoi empty");
    tgt_ready = 1'b0;
    post(31'h31, 1, BASE + 8, 1, 0, 0, "R9 failed no escalate");
    tgt_ready = 1'b1;
    post(31'h32, 1, BASE + 12, 1, 0, 0, "R7 P still set");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_drops();
    t_coalesce_wrap();
    t_always_reenable();
    t_fail_no_esc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule